// File: doc/BRIEF.md
# DMA Port Variable-Timing Bus Cycle Generator

This block produces the active-low bus strobes for one port of a DMA transfer engine, one read or write cycle at a time. A small base setting picks whether the port sits in memory space or I/O space and how its address moves after each transfer. An optional timing byte shortens or lengthens the cycle to two, three or four clocks, and lets any strobe let go half a clock before the cycle ends.

The engine loads a starting address, then asks for a cycle with a start request and a direction. The block asserts the space strobe (memory or I/O) together with the read or write strobe. When the cycle ends it gives a one-clock done pulse and steps the address. Once a timing byte has been written, the I/O strobe moves on falling clock edges while the others move on rising edges. Strobes therefore come from both clock edges.

Top module: `dma_port_timing`

## Requirements
- R1: A synchronous active-low reset drives `mreq_n`, `iorq_n`, `rd_n` and `wr_n` high and `done` low. It clears the address to zero and `cfg_err` to 0. It restores the default configuration: memory port, decrementing address, timing byte never written.
- R2: Base field bit 0 selects the space. With 0, the port asserts only `mreq_n`. With 1, it asserts only `iorq_n`. The two are never low together.
- R3: Timing byte bits [1:0] set the cycle length: 00 gives 4 clocks, 01 gives 3 and 10 gives 2. The space strobe asserts at the first rising edge that samples `start` high while idle, and the cycle covers that many clocks from that edge.
- R4: A read (`dir_wr`=0) asserts `rd_n` from the first clock. A write (`dir_wr`=1) asserts `wr_n` from the second clock. `rd_n` and `wr_n` are never low together.
- R5: Timing byte bits 7, 6, 3 and 2 control the WR, RD, MREQ and IORQ strobes respectively. A 0 in a bit releases that strobe at the falling edge inside the last clock, half a clock before the cycle end.
- R6: Once any timing byte has been written, the I/O strobe asserts at the falling edge of the first clock. Without early release, it lets go at the falling edge after the cycle end. With early release (bit 2 = 0), it lets go at the rising edge that ends the cycle.
- R7: A length code of 11 runs a 4-clock cycle and sets `cfg_err`. `cfg_err` then stays set until reset.
- R8: `done` is high for exactly the one clock that follows the last clock of the cycle.
- R9: Base field bits [2:1] set the address step: 00 decrements, 01 increments, and 10 or 11 hold the address. The step is applied at the rising edge that ends the cycle and wraps modulo 2^AW.
- R10: `addr_ld` loads `addr_in` into the address at a rising edge while idle.
- R11: While a cycle runs, `start`, `base_we`, `tim_we` and `addr_ld` are ignored. The running cycle is not lengthened, and later cycles still use the earlier configuration.
- R12: Until a timing byte is written, cycles last 3 clocks, no strobe releases early and `iorq_n` moves on rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; strobes move on both edges |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Write strobe for the base field |
| base_data | input | 3 | Bit 0 space select, bits [2:1] address step |
| tim_we | input | 1 | Write strobe for the timing byte |
| tim_data | input | 8 | Timing byte: early bits 7,6,3,2; length bits [1:0] |
| addr_ld | input | 1 | Load `addr_in` while idle |
| addr_in | input | AW | Starting address |
| start | input | 1 | Request one bus cycle |
| dir_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| mreq_n | output | 1 | Memory request strobe, active low |
| iorq_n | output | 1 | I/O request strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_out | output | AW | Current port address |
| done | output | 1 | One-clock end-of-cycle pulse |
| cfg_err | output | 1 | Sticky flag for the reserved length code |

## Verification
The bench samples every strobe in both halves of each clock. It sweeps all three legal lengths against all sixteen early-release masks, both spaces and both directions. This separates errors in cycle length from errors in which edge releases a strobe, and it shows whether IORQ follows the opposite-edge rule. Runs before any timing write show the default timing. The address-step codes rotate through the sweep, and runs from zero and from all ones check wrap in both directions. A cycle poked with a start request and a space-flipping base write shows that both are ignored while busy. The reserved length code checks the fallback length and the sticky error flag.

// File: rtl/dmat_pkg.sv
`timescale 1ns/1ps
// Package: shared configuration type, field positions and length decode
// for the DMA port timing generator. Assumes an 8-bit timing byte.
package dmat_pkg;

    // Bit positions inside the timing byte (behavioural: each picks a strobe).
    localparam int TB_WR   = 7;
    localparam int TB_RD   = 6;
    localparam int TB_MREQ = 3;
    localparam int TB_IORQ = 2;
    localparam logic [1:0] LEN_DEFAULT = 2'b01;
    localparam logic [1:0] LEN_RESVD   = 2'b11;

    // Address step codes.
    localparam logic [1:0] STEP_DN = 2'b00;
    localparam logic [1:0] STEP_UP = 2'b01;

    // Live port configuration; e_* = 1 means "release half a clock early".
    typedef struct packed {
        logic       is_io;
        logic [1:0] step;
        logic [1:0] len;
        logic       e_wr;
        logic       e_rd;
        logic       e_m;
        logic       e_io;
        logic       var_on;
    } port_cfg_t;

    // Number of clocks in a cycle for a length code; reserved code -> 4.
    function automatic logic [2:0] cyc_clocks(input logic [1:0] code);
        case (code)
            2'b00:   return 3'd4;
            2'b01:   return 3'd3;
            2'b10:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dmat_cfg.sv
`timescale 1ns/1ps
// Module: dmat_cfg
// Holds the base field and the decoded timing byte, plus the sticky
// reserved-length flag. Writes are accepted only while the port is idle,
// so the configuration is frozen for the length of a cycle.
module dmat_cfg
    import dmat_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            idle,
    input  logic            base_we,
    input  logic [2:0]      base_data,
    input  logic            tim_we,
    input  logic [7:0]      tim_data,
    output port_cfg_t       cfg,
    output logic            cfg_err
);

    logic unused_tim_bits;
    assign unused_tim_bits = ^{tim_data[5:4], tim_data[1]};

    // Configuration register: reset defaults, then idle-time writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg.is_io  <= 1'b0;
            cfg.step   <= STEP_DN;
            cfg.len    <= LEN_DEFAULT;
            cfg.e_wr   <= 1'b0;
            cfg.e_rd   <= 1'b0;
            cfg.e_m    <= 1'b0;
            cfg.e_io   <= 1'b0;
            cfg.var_on <= 1'b0;
        end else if (idle) begin
            if (base_we) begin
                cfg.is_io <= base_data[0];
                cfg.step  <= base_data[2:1];
            end
            if (tim_we) begin
                cfg.len    <= tim_data[1:0];
                cfg.e_wr   <= ~tim_data[TB_WR];
                cfg.e_rd   <= ~tim_data[TB_RD];
                cfg.e_m    <= ~tim_data[TB_MREQ];
                cfg.e_io   <= ~tim_data[TB_IORQ];
                cfg.var_on <= 1'b1;
            end
        end
    end

    // Sticky error: set by an idle write of the reserved length code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else if (idle && tim_we && (tim_data[1:0] == LEN_RESVD))
            cfg_err <= 1'b1;
    end

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    p_err_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && tim_we && tim_data[1:0] == LEN_RESVD) |=> cfg_err);

    p_cfg_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(cfg));

endmodule

// File: rtl/dmat_seq.sv
`timescale 1ns/1ps
// Module: dmat_seq
// Rising-edge cycle sequencer: accepts a start while idle, counts the
// clocks of the cycle against the configured length and issues the
// one-clock done pulse. Assumes cyc_len is 2..4 and stable while busy.
module dmat_seq #(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_wr,
    input  logic [CW:0]   cyc_len,
    output logic          busy,
    output logic [CW-1:0] cnt,
    output logic          wr_dir,
    output logic          last,
    output logic          done
);

    // Marks the final clock of a running cycle.
    always_comb begin
        last = busy && ({1'b0, cnt} == (cyc_len - 1'b1));
    end

    // Cycle state: idle -> counting -> done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            cnt    <= '0;
            wr_dir <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy   <= 1'b1;
                    cnt    <= '0;
                    wr_dir <= dir_wr;
                end
            end else if (last) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    p_start_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && cnt == '0));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> (done && !busy));

    p_no_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> (busy && cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/dmat_addr.sv
`timescale 1ns/1ps
// Module: dmat_addr
// Port address register: loaded while idle, stepped at the edge that
// ends a cycle. Assumes step is stable while a cycle runs.
module dmat_addr
    import dmat_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          idle,
    input  logic          ld,
    input  logic [AW-1:0] addr_in,
    input  logic [1:0]    step,
    input  logic          adv,
    output logic [AW-1:0] addr
);

    // Address update: load, or step after a transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (idle && ld) begin
            addr <= addr_in;
        end else if (adv) begin
            case (step)
                STEP_DN: addr <= addr - 1'b1;
                STEP_UP: addr <= addr + 1'b1;
                default: addr <= addr;
            endcase
        end
    end

    p_step_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && step == STEP_UP) |=> (addr == $past(addr) + 1'b1));

    p_step_dn_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && step == STEP_DN) |=> (addr == $past(addr) - 1'b1));

    p_step_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && step[1]) |=> $stable(addr));

endmodule

// File: rtl/dmat_strobe.sv
`timescale 1ns/1ps
// Module: dmat_strobe
// Builds the four active-low strobes. Rising-edge state comes from the
// sequencer; two falling-edge flops mark the second half of the last
// clock and carry the I/O request shifted by half a clock.
module dmat_strobe
    import dmat_pkg::*;
#(
    parameter int CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic          last,
    input  logic [CW-1:0] cnt,
    input  logic          wr_dir,
    input  port_cfg_t     cfg,
    output logic          mreq_n,
    output logic          iorq_n,
    output logic          rd_n,
    output logic          wr_n
);

    logic last_h;
    logic io_h;
    logic mreq_on, iorq_on, rd_on, wr_on;

    // Falling-edge half-clock markers.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            last_h <= 1'b0;
            io_h   <= 1'b0;
        end else begin
            last_h <= last;
            io_h   <= busy && cfg.is_io;
        end
    end

    // Strobe decode, with early release in the last half clock.
    always_comb begin
        mreq_on = busy && !cfg.is_io && !(cfg.e_m && last_h);
        rd_on   = busy && !wr_dir && !(cfg.e_rd && last_h);
        wr_on   = busy && wr_dir && (cnt != '0) && !(cfg.e_wr && last_h);
        if (cfg.var_on)
            iorq_on = io_h && (busy || !cfg.e_io);
        else
            iorq_on = busy && cfg.is_io && !(cfg.e_io && last_h);
    end

    // Drive the active-low outputs.
    always_comb begin
        mreq_n = !mreq_on;
        iorq_n = !iorq_on;
        rd_n   = !rd_on;
        wr_n   = !wr_on;
    end

    p_rw_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    p_space_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mreq_n && !iorq_n));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> (mreq_n && iorq_n && rd_n && wr_n));

    p_wr_late_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt == '0) |-> wr_n);

endmodule

// File: rtl/dma_port_timing.sv
`timescale 1ns/1ps
// Module: dma_port_timing (top)
// One DMA port's bus cycle generator: configuration, rising-edge
// sequencer, address register and dual-edge strobe decode.
// Assumes the engine waits for done before the next start.
module dma_port_timing
    import dmat_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [2:0]    base_data,
    input  logic          tim_we,
    input  logic [7:0]    tim_data,
    input  logic          addr_ld,
    input  logic [AW-1:0] addr_in,
    input  logic          start,
    input  logic          dir_wr,
    output logic          mreq_n,
    output logic          iorq_n,
    output logic          rd_n,
    output logic          wr_n,
    output logic [AW-1:0] addr_out,
    output logic          done,
    output logic          cfg_err
);

    localparam int CW = 2;

    port_cfg_t     cfg;
    logic          busy, last, wr_dir, idle;
    logic [CW-1:0] cnt;
    logic [CW:0]   cyc_len;

    assign idle    = !busy;
    assign cyc_len = cyc_clocks(cfg.len);

    dmat_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .idle(idle),
        .base_we(base_we), .base_data(base_data),
        .tim_we(tim_we), .tim_data(tim_data),
        .cfg(cfg), .cfg_err(cfg_err)
    );

    dmat_seq #(.CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_wr(dir_wr),
        .cyc_len(cyc_len), .busy(busy), .cnt(cnt), .wr_dir(wr_dir),
        .last(last), .done(done)
    );

    dmat_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst_n(rst_n), .idle(idle), .ld(addr_ld),
        .addr_in(addr_in), .step(cfg.step), .adv(last), .addr(addr_out)
    );

    dmat_strobe #(.CW(CW)) u_strobe (
        .clk(clk), .rst_n(rst_n), .busy(busy), .last(last), .cnt(cnt),
        .wr_dir(wr_dir), .cfg(cfg),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n)
    );

endmodule

// File: tb/sim_dma_port_timing.sv
`timescale 1ns/1ps
// Bench: half-clock sampling of all strobes over a sweep of lengths,
// early masks, spaces and directions; expected waveforms computed here.
module sim_dma_port_timing;

    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          base_we = 1'b0;
    logic [2:0]    base_data = '0;
    logic          tim_we = 1'b0;
    logic [7:0]    tim_data = '0;
    logic          addr_ld = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          start = 1'b0;
    logic          dir_wr = 1'b0;
    logic          mreq_n, iorq_n, rd_n, wr_n, done, cfg_err;
    logic [AW-1:0] addr_out;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    // bench-side model of the configuration
    bit            m_io = 0;
    logic [1:0]    m_step = 2'b00;
    logic [AW-1:0] m_addr = '0;

    always #2.5 clk = ~clk;

    dma_port_timing #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_data(base_data),
        .tim_we(tim_we), .tim_data(tim_data), .addr_ld(addr_ld),
        .addr_in(addr_in), .start(start), .dir_wr(dir_wr),
        .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr_out(addr_out), .done(done), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wr_base(input bit io, input logic [1:0] stp);
        @(posedge clk); #1;
        base_we = 1'b1; base_data = {stp, io};
        @(posedge clk); #1;
        base_we = 1'b0;
        m_io = io; m_step = stp;
    endtask

    task automatic wr_tim(input logic [7:0] b);
        @(posedge clk); #1;
        tim_we = 1'b1; tim_data = b;
        @(posedge clk); #1;
        tim_we = 1'b0;
    endtask

    task automatic load_addr(input logic [AW-1:0] a);
        @(posedge clk); #1;
        addr_ld = 1'b1; addr_in = a;
        @(posedge clk); #1;
        addr_ld = 1'b0;
        m_addr = a;
    endtask

    // One cycle: n clocks, early flags ew/er/em/ei (1 = early), var = timing
    // byte written. poke drives start and a flipped base write mid-cycle.
    task automatic run_cycle(input string req, input bit dwr, input int n,
                             input bit var_on, input bit ew, input bit er,
                             input bit em, input bit ei, input bit poke);
        logic [11:0] am, ai, ar, aw, ad, xm, xi, xr, xw, xd;
        int h;
        am = '0; ai = '0; ar = '0; aw = '0; ad = '0;
        xm = '0; xi = '0; xr = '0; xw = '0; xd = '0;
        h = 2 * n;
        for (int k = 0; k < h + 2; k++) begin
            if (!m_io && k < h - int'(em)) xm[k] = 1'b1;
            if (!dwr && k < h - int'(er)) xr[k] = 1'b1;
            if (dwr && k >= 2 && k < h - int'(ew)) xw[k] = 1'b1;
            if (m_io) begin
                if (var_on) begin
                    if (k >= 1 && k < h + 1 - int'(ei)) xi[k] = 1'b1;
                end else if (k < h - int'(ei)) xi[k] = 1'b1;
            end
            if (k == h || k == h + 1) xd[k] = 1'b1;
        end
        @(posedge clk); #1;
        start = 1'b1; dir_wr = dwr;
        @(posedge clk); #1;
        for (int k = 0; k < h + 2; k++) begin
            am[k] = ~mreq_n; ai[k] = ~iorq_n; ar[k] = ~rd_n;
            aw[k] = ~wr_n;   ad[k] = done;
            if (k == 0) start = 1'b0;
            if (poke && k == 2) begin
                start = 1'b1; base_we = 1'b1; base_data = {m_step, ~m_io};
                addr_ld = 1'b1; addr_in = 16'h5A5A;
            end
            if (poke && k == 4) begin
                start = 1'b0; base_we = 1'b0; addr_ld = 1'b0;
            end
            #2.5;
        end
        case (m_step)
            2'b00:   m_addr = m_addr - 1'b1;
            2'b01:   m_addr = m_addr + 1'b1;
            default: m_addr = m_addr;
        endcase
        chk(req, "mreq halves", {20'd0, am}, {20'd0, xm});
        chk(req, "iorq halves", {20'd0, ai}, {20'd0, xi});
        chk(req, "rd halves",   {20'd0, ar}, {20'd0, xr});
        chk(req, "wr halves",   {20'd0, aw}, {20'd0, xw});
        chk("R8", "done halves", {20'd0, ad}, {20'd0, xd});
        chk("R9", "addr after cycle", {16'd0, addr_out}, {16'd0, m_addr});
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_io = 0; m_step = 2'b00; m_addr = '0;
    endtask

    // Watchdog
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [7:0] tb;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "strobes high", {28'd0, mreq_n, iorq_n, rd_n, wr_n}, 32'hF);
        chk("R1", "done low", {31'd0, done}, 32'd0);
        chk("R1", "err low", {31'd0, cfg_err}, 32'd0);
        chk("R1", "addr zero", {16'd0, addr_out}, 32'd0);
        rst_n = 1'b1;

        // R12: default timing, rising-edge IORQ, R2 both spaces
        load_addr(16'h0010);
        chk("R10", "addr load", {16'd0, addr_out}, 32'h0010);
        run_cycle("R12", 1'b0, 3, 1'b0, 0, 0, 0, 0, 0);
        run_cycle("R12", 1'b1, 3, 1'b0, 0, 0, 0, 0, 0);
        wr_base(1'b1, 2'b01);
        run_cycle("R12", 1'b0, 3, 1'b0, 0, 0, 0, 0, 0);
        run_cycle("R2",  1'b1, 3, 1'b0, 0, 0, 0, 0, 0);

        // R3 R4 R5 R6: sweep lengths x early masks x space x direction
        load_addr(16'h8000);
        for (int ln = 0; ln < 3; ln++) begin
            for (int msk = 0; msk < 16; msk++) begin
                tb = {~msk[3], ~msk[2], 2'b00, ~msk[1], ~msk[0], ln[1:0]};
                wr_tim(tb);
                for (int io = 0; io < 2; io++) begin
                    wr_base(io[0], 2'(msk + ln + io));
                    for (int d = 0; d < 2; d++) begin
                        run_cycle(io[0] ? "R6" : "R5", d[0], 4 - ln, 1'b1,
                                  msk[3], msk[2], msk[1], msk[0], 0);
                    end
                end
            end
        end
        chk("R7", "err clear after legal codes", {31'd0, cfg_err}, 32'd0);

        // R7: reserved length -> 4 clocks, sticky flag
        wr_base(1'b0, 2'b01);
        wr_tim(8'hCF);
        chk("R7", "err set", {31'd0, cfg_err}, 32'd1);
        run_cycle("R7", 1'b0, 4, 1'b1, 0, 0, 0, 0, 0);
        run_cycle("R7", 1'b1, 4, 1'b1, 0, 0, 0, 0, 0);
        wr_tim(8'hCE);
        chk("R7", "err sticky", {31'd0, cfg_err}, 32'd1);

        // R11: start, base write and load during a cycle are ignored
        run_cycle("R11", 1'b0, 2, 1'b1, 0, 0, 0, 0, 1);
        run_cycle("R11", 1'b1, 2, 1'b1, 0, 0, 0, 0, 0);

        // R9: wrap both ways, and hold
        wr_base(1'b0, 2'b00);
        load_addr(16'h0000);
        run_cycle("R9", 1'b0, 2, 1'b1, 0, 0, 0, 0, 0);
        chk("R9", "dec wrap", {16'd0, addr_out}, 32'h0000FFFF);
        wr_base(1'b0, 2'b01);
        run_cycle("R9", 1'b0, 2, 1'b1, 0, 0, 0, 0, 0);
        chk("R9", "inc wrap", {16'd0, addr_out}, 32'h00000000);
        wr_base(1'b1, 2'b11);
        run_cycle("R9", 1'b1, 2, 1'b1, 0, 0, 0, 0, 0);
        chk("R9", "hold", {16'd0, addr_out}, 32'h00000000);

        // R1: reset restores defaults (memory, decrement, 3 clocks, err 0)
        wr_tim(8'h02);
        load_addr(16'h1234);
        do_reset();
        chk("R1", "err cleared", {31'd0, cfg_err}, 32'd0);
        chk("R1", "addr cleared", {16'd0, addr_out}, 32'd0);
        run_cycle("R1", 1'b0, 3, 1'b0, 0, 0, 0, 0, 0);
        chk("R1", "default step dec", {16'd0, addr_out}, 32'h0000FFFF);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule